// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a processor's load/store port and a word-addressed backing memory. It holds 16 lines of 32 words each, 2 KB of data in total, with one way per set. Loads and stores of 32-bit words that hit are served in the cycle they are presented. A miss stalls the processor while the line is brought in from memory. If the line being replaced holds modified data, that line is first copied out to memory.

Stores follow a write-back, write-allocate policy. A store hit changes only the cached copy and marks the line modified. A store miss first fetches the line and then merges the store word into it. Three free-running counters record completed accesses, misses, and evictions of modified lines.

The memory side moves one word per request/acknowledge handshake. Within a burst, word addresses climb from the base of the line.

Top module: `dcache_top`

## Requirements
- R1: After reset every line is invalid, all three counters read zero, and `stall_o` and `mem_req_o` are low. The first access after reset therefore misses.
- R2: A read hit drives the addressed word on `cpu_rdata_o` with `stall_o` low in the same cycle, and it raises no memory request.
- R3: A miss on a clean or invalid line makes 32 read transfers (`mem_we_o`=0). Their word addresses are {tag, index, 0..31} in ascending order. After the fill, the requested word is returned.
- R4: A write hit updates the cached word with no memory traffic. Later reads return the new value.
- R5: A miss on a modified line first makes 32 write transfers of the old line, at {old tag, index, 0..31} ascending, carrying the current cached data. The 32 reads of the new line follow.
- R6: A write miss fetches the line, merges the store word, and marks the line modified. Its later eviction writes the merged word back.
- R7: `stall_o` is high from the cycle a miss is detected until the access completes. With one memory wait cycle per word, the stall lasts 64 cycles for a clean miss and 128 cycles for a modified miss. `stall_o` is low while no request is presented.
- R8: `stat_access_o` counts completed accesses. `stat_miss_o` counts misses. `stat_wb_o` counts evictions of modified lines.
- R9: Evicting a line that was only read causes no write transfer.
- R10: The byte address splits into bits [1:0] (ignored), word [6:2], index [10:7] and tag [31:11].
- R11: While `mem_req_o` is high and `mem_ack_i` is low, the request, address, direction and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_req_i | input | 1 | Access request, held until `stall_o` is low |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_addr_i | input | 32 | Byte address |
| cpu_wdata_i | input | 32 | Store data |
| cpu_rdata_o | output | 32 | Load data, valid when request is high and stall low |
| stall_o | output | 1 | Processor must hold its request |
| mem_req_o | output | 1 | Memory transfer request |
| mem_we_o | output | 1 | 1 = write to memory, 0 = read |
| mem_addr_o | output | 30 | Word address of the transfer |
| mem_wdata_o | output | 32 | Write data to memory |
| mem_rdata_i | input | 32 | Read data from memory, taken with acknowledge |
| mem_ack_i | input | 1 | Completes one word transfer |
| stat_access_o | output | 32 | Completed access count |
| stat_miss_o | output | 32 | Miss count |
| stat_wb_o | output | 32 | Modified-line eviction count |

## Verification
The assertions assume the processor holds `cpu_req_i`, `cpu_we_i`, `cpu_addr_i` and `cpu_wdata_i` steady while `stall_o` is high. The burst address and the hold-until-acknowledge checks depend on the address the processor keeps presenting. They also assume memory acknowledges only while a request is raised. The stimulus changes processor inputs only after a cycle in which `stall_o` was low. The memory model raises acknowledge for one cycle at a time, and only in answer to a pending request.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_FILL = 2'd2
  } dc_state_e;
endpackage

// File: rtl/dcache_tag_store.sv
module dcache_tag_store #(
  parameter int SETS  = 16,
  parameter int TAG_W = 21,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             fill_done_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic             mark_dirty_i,
  output logic             valid_o,
  output logic             dirty_o,
  output logic [TAG_W-1:0] tag_o
);
  logic [SETS-1:0] valid_q, dirty_q;
  logic [TAG_W-1:0] tag_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_done_i) begin
      valid_q[idx_i] <= 1'b1;
      dirty_q[idx_i] <= 1'b0;
    end else if (mark_dirty_i) begin
      dirty_q[idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_done_i) tag_q[idx_i] <= fill_tag_i;
  end

  assign valid_o = valid_q[idx_i];
  assign dirty_o = dirty_q[idx_i];
  assign tag_o   = tag_q[idx_i];
endmodule

// File: rtl/dcache_data_store.sv
module dcache_data_store #(
  parameter int SETS       = 16,
  parameter int LINE_WORDS = 32,
  parameter int DATA_W     = 32,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WORD_W = $clog2(LINE_WORDS),
  localparam int DEPTH  = SETS * LINE_WORDS
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] wr_word_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [WORD_W-1:0] cpu_word_i,
  input  logic [WORD_W-1:0] ev_word_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic [DATA_W-1:0] ev_rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[{idx_i, wr_word_i}] <= wdata_i;
  end

  assign cpu_rdata_o = mem_q[{idx_i, cpu_word_i}];
  assign ev_rdata_o  = mem_q[{idx_i, ev_word_i}];
endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
  import dcache_pkg::*;
#(
  parameter int LINE_WORDS = 32,
  localparam int WORD_W = $clog2(LINE_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic              hit_i,
  input  logic              victim_dirty_i,
  input  logic              mem_ack_i,
  output logic              stall_o,
  output logic              wb_phase_o,
  output logic              fill_phase_o,
  output logic [WORD_W-1:0] beat_o,
  output logic              fill_wr_o,
  output logic              fill_done_o,
  output logic              cpu_wr_hit_o,
  output logic              ev_access_o,
  output logic              ev_miss_o,
  output logic              ev_wb_o
);
  localparam logic [WORD_W-1:0] LAST = WORD_W'(LINE_WORDS - 1);

  dc_state_e state_q, state_d;
  logic [WORD_W-1:0] beat_q, beat_d;
  logic idle, access_ok, miss_start, last_beat;

  assign idle       = (state_q == ST_IDLE);
  assign access_ok  = idle & cpu_req_i & hit_i;
  assign miss_start = idle & cpu_req_i & ~hit_i;
  assign last_beat  = (beat_q == LAST);

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    unique case (state_q)
      ST_IDLE: if (miss_start) begin
        state_d = victim_dirty_i ? ST_WB : ST_FILL;
        beat_d  = '0;
      end
      ST_WB: if (mem_ack_i) begin
        beat_d = beat_q + 1'b1;
        if (last_beat) begin
          state_d = ST_FILL;
          beat_d  = '0;
        end
      end
      ST_FILL: if (mem_ack_i) begin
        beat_d = beat_q + 1'b1;
        if (last_beat) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
    end
  end

  assign stall_o      = cpu_req_i & ~access_ok;
  assign wb_phase_o   = (state_q == ST_WB);
  assign fill_phase_o = (state_q == ST_FILL);
  assign beat_o       = beat_q;
  assign fill_wr_o    = fill_phase_o & mem_ack_i;
  assign fill_done_o  = fill_wr_o & last_beat;
  assign cpu_wr_hit_o = access_ok & cpu_we_i;
  assign ev_access_o  = access_ok;
  assign ev_miss_o    = miss_start;
  assign ev_wb_o      = miss_start & victim_dirty_i;
endmodule

// File: rtl/dcache_stats.sv
module dcache_stats #(
  parameter int LANES = 3,
  parameter int CNT_W = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [LANES-1:0]            inc_i,
  output logic [LANES-1:0][CNT_W-1:0] cnt_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_q <= '0;
      else if (inc_i[g]) cnt_q <= cnt_q + 1'b1;
    end
    assign cnt_o[g] = cnt_q;
  end
endmodule

// File: rtl/dcache_top.sv
module dcache_top #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int SETS       = 16,
  parameter int LINE_WORDS = 32,
  parameter int CNT_W      = 32,
  localparam int BO_W   = $clog2(DATA_W / 8),
  localparam int WORD_W = $clog2(LINE_WORDS),
  localparam int IDX_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - IDX_W - WORD_W - BO_W,
  localparam int MEM_AW = ADDR_W - BO_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              stall_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i,
  output logic [CNT_W-1:0]  stat_access_o,
  output logic [CNT_W-1:0]  stat_miss_o,
  output logic [CNT_W-1:0]  stat_wb_o
);
  logic [WORD_W-1:0] a_word;
  logic [IDX_W-1:0]  a_idx;
  logic [TAG_W-1:0]  a_tag;
  logic              unused_byte;

  assign a_word      = cpu_addr_i[BO_W +: WORD_W];
  assign a_idx       = cpu_addr_i[BO_W + WORD_W +: IDX_W];
  assign a_tag       = cpu_addr_i[ADDR_W-1 -: TAG_W];
  assign unused_byte = ^cpu_addr_i[BO_W-1:0];

  logic              l_valid, l_dirty, hit;
  logic [TAG_W-1:0]  l_tag;
  logic              wb_ph, fill_ph, fill_wr, fill_done, wr_hit;
  logic [WORD_W-1:0] beat;
  logic              ev_acc, ev_miss, ev_wb;

  assign hit = l_valid & (l_tag == a_tag);

  dcache_ctrl #(.LINE_WORDS(LINE_WORDS)) u_ctrl (
    .clk_i, .rst_ni, .cpu_req_i, .cpu_we_i,
    .hit_i(hit), .victim_dirty_i(l_valid & l_dirty), .mem_ack_i,
    .stall_o, .wb_phase_o(wb_ph), .fill_phase_o(fill_ph), .beat_o(beat),
    .fill_wr_o(fill_wr), .fill_done_o(fill_done), .cpu_wr_hit_o(wr_hit),
    .ev_access_o(ev_acc), .ev_miss_o(ev_miss), .ev_wb_o(ev_wb)
  );

  dcache_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk_i, .rst_ni, .idx_i(a_idx),
    .fill_done_i(fill_done), .fill_tag_i(a_tag), .mark_dirty_i(wr_hit),
    .valid_o(l_valid), .dirty_o(l_dirty), .tag_o(l_tag)
  );

  dcache_data_store #(.SETS(SETS), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)) u_data (
    .clk_i,
    .we_i(fill_wr | wr_hit),
    .idx_i(a_idx),
    .wr_word_i(fill_wr ? beat : a_word),
    .wdata_i(fill_wr ? mem_rdata_i : cpu_wdata_i),
    .cpu_word_i(a_word),
    .ev_word_i(beat),
    .cpu_rdata_o,
    .ev_rdata_o(mem_wdata_o)
  );

  assign mem_req_o  = wb_ph | fill_ph;
  assign mem_we_o   = wb_ph;
  assign mem_addr_o = {(wb_ph ? l_tag : a_tag), a_idx, beat};

  logic [2:0][CNT_W-1:0] cnts;

  dcache_stats #(.LANES(3), .CNT_W(CNT_W)) u_stats (
    .clk_i, .rst_ni, .inc_i({ev_wb, ev_miss, ev_acc}), .cnt_o(cnts)
  );

  assign stat_access_o = cnts[0];
  assign stat_miss_o   = cnts[1];
  assign stat_wb_o     = cnts[2];
endmodule

// File: rtl/dcache_chk.sv
module dcache_chk #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 32,
  parameter int CNT_W      = 32,
  localparam int BO_W   = $clog2(DATA_W / 8),
  localparam int WORD_W = $clog2(LINE_WORDS),
  localparam int MEM_AW = ADDR_W - BO_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic              stall_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [MEM_AW-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_ack_i,
  input logic [CNT_W-1:0]  stat_access_o,
  input logic [CNT_W-1:0]  stat_miss_o
);
  a_r11_hold_until_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) &&
                                $stable(mem_we_o) && $stable(mem_wdata_o));

  a_r3_burst_ascends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i && (mem_addr_o[WORD_W-1:0] != {WORD_W{1'b1}})
    |=> mem_addr_o == $past(mem_addr_o) + 1'b1);

  a_r2_hit_no_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && !stall_o |-> !mem_req_o);

  a_r7_stall_in_transfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && mem_req_o |-> stall_o);

  a_r8_access_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && !stall_o |=> stat_access_o == $past(stat_access_o) + 1'b1);

  a_r8_miss_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && stall_o && !mem_req_o |=> stat_miss_o == $past(stat_miss_o) + 1'b1);
endmodule

bind dcache_top dcache_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cpu_req_i(cpu_req_i), .stall_o(stall_o),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
  .stat_access_o(stat_access_o), .stat_miss_o(stat_miss_o)
);

// File: tb/sim_dcache_top.sv
module sim_dcache_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        stall;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [29:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic [31:0] st_acc, st_miss, st_wb;

  always #10 clk = ~clk;

  dcache_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .cpu_req_i(cpu_req), .cpu_we_i(cpu_we),
    .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata),
    .stall_o(stall), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_ack_i(mem_ack), .stat_access_o(st_acc), .stat_miss_o(st_miss),
    .stat_wb_o(st_wb)
  );

  typedef struct packed {
    logic        we;
    logic [29:0] addr;
    logic [31:0] data;
  } xfer_t;

  xfer_t       exp_q[$];
  logic [31:0] bmem [logic [29:0]];
  logic [31:0] gmem [logic [29:0]];
  logic        sv [16];
  logic        sd [16];
  logic [20:0] stg [16];
  int          checks = 0, fails = 0;
  int          e_acc = 0, e_miss = 0, e_wb = 0;

  function automatic logic [31:0] init_word(logic [29:0] a);
    return {a, 2'b01} ^ 32'hC3A5_0F1E;
  endfunction

  function automatic logic [31:0] bval(logic [29:0] a);
    return bmem.exists(a) ? bmem[a] : init_word(a);
  endfunction

  function automatic logic [31:0] gval(logic [29:0] a);
    return gmem.exists(a) ? gmem[a] : init_word(a);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // memory model and transfer monitor
  always @(negedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2/R9", "unexpected memory transfer", {2'b0, mem_addr}, 32'h0);
      end else begin
        xfer_t e;
        e = exp_q.pop_front();
        chk(mem_we == e.we, e.we ? "R5" : "R3", "transfer direction", {31'b0, mem_we}, {31'b0, e.we});
        chk(mem_addr == e.addr, e.we ? "R5" : "R3", "transfer address", {2'b0, mem_addr}, {2'b0, e.addr});
        if (e.we) chk(mem_wdata == e.data, "R5/R6", "write-back data", mem_wdata, e.data);
      end
      if (mem_we) bmem[mem_addr] = mem_wdata;
      mem_rdata <= bval(mem_addr);
      mem_ack <= 1'b1;
    end
  end

  task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] wd,
                        input string req);
    logic [3:0]  idx;
    logic [20:0] tg;
    logic [29:0] wa;
    bit          hit, vd;
    int          n;
    idx = addr[10:7];
    tg  = addr[31:11];
    wa  = addr[31:2];
    hit = sv[idx] && stg[idx] == tg;
    vd  = sv[idx] && sd[idx];
    if (!hit) begin
      e_miss++;
      if (vd) begin
        e_wb++;
        for (int w = 0; w < 32; w++)
          exp_q.push_back('{1'b1, {stg[idx], idx, 5'(w)}, gval({stg[idx], idx, 5'(w)})});
      end
      for (int w = 0; w < 32; w++)
        exp_q.push_back('{1'b0, {tg, idx, 5'(w)}, 32'h0});
      sv[idx] = 1'b1; sd[idx] = 1'b0; stg[idx] = tg;
    end
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    #1;
    chk(stall == !hit, "R7", "stall at detection", {31'b0, stall}, {31'b0, !hit});
    n = stall ? 1 : 0;
    while (stall) begin
      @(negedge clk); #1;
      if (stall) n++;
    end
    if (!hit)
      chk(n == (vd ? 128 : 64), "R7", "stall length", n, vd ? 128 : 64);
    if (!we)
      chk(cpu_rdata == gval(wa), req, "read data", cpu_rdata, gval(wa));
    @(posedge clk);
    e_acc++;
    if (we) begin
      gmem[wa] = wd;
      sd[idx] = 1'b1;
    end
    @(negedge clk);
    cpu_req = 1'b0;
    #1;
    chk(stall == 1'b0, "R7", "stall low when idle", {31'b0, stall}, 32'h0);
    chk(exp_q.size() == 0, "R3/R5", "pending transfers", exp_q.size(), 0);
  endtask

  task automatic check_counts(input string tag);
    chk(st_acc == e_acc, "R8", {tag, " access count"}, st_acc, e_acc);
    chk(st_miss == e_miss, "R8", {tag, " miss count"}, st_miss, e_miss);
    chk(st_wb == e_wb, "R8", {tag, " write-back count"}, st_wb, e_wb);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "WATCHDOG", "run did not finish", 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin sv[i] = 0; sd[i] = 0; stg[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(stall == 0, "R1", "stall after reset", {31'b0, stall}, 0);
    chk(mem_req == 0, "R1", "mem_req after reset", {31'b0, mem_req}, 0);
    check_counts("R1");
    // R1 R3: first access misses on a clean, invalid line
    access(0, 32'h0000_0100, 0, "R3");
    // R2 hit; R10 byte bits ignored
    access(0, 32'h0000_0104, 0, "R2");
    access(0, 32'h0000_0107, 0, "R10");
    access(0, 32'h0000_017C, 0, "R2");
    // R4 write hit, then read back
    access(1, 32'h0000_0108, 32'hDEAD_BEEF, "R4");
    access(0, 32'h0000_0108, 0, "R4");
    check_counts("mid");
    // R5 dirty eviction, same index with a new tag
    access(0, 32'h0000_0904, 0, "R5");
    // R9 clean eviction brings back the earlier store
    access(0, 32'h0000_0108, 0, "R9");
    // R6 write miss allocates and merges
    access(1, 32'h0000_2010, 32'h1234_5678, "R6");
    access(0, 32'h0000_2010, 0, "R6");
    access(0, 32'h0000_2014, 0, "R6");
    access(0, 32'h0000_3000, 0, "R6");
    // R10 index field separates lines
    access(0, 32'h0000_0780, 0, "R10");
    access(0, 32'h0000_0010, 0, "R10");
    check_counts("end");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule